// File: doc/BRIEF.md
# Two-Level Interrupt Router with Exclusive Enables

This block collects level-sensitive request lines from peripherals and external pins and steers each one to one of two processor exception outputs: a normal request and a fast request that the processor treats as more urgent. Software sets up the routing through a small synchronous register bus. For each level there is a raw view of the lines, an enable mask, a write-one-to-clear port for that mask, and a masked view.

A source may be enabled on at most one level at a time. Setting a source's enable on one level removes it from the other level in the same write. A separate configuration word injects a software interrupt into either level or both. This injection ignores every mask. The block does no priority encoding and produces no vector: the handler scans the masked view to find the source.

Top module: `irq_dual_router`

Bit layout, shared by every level register: bit 0 is the level summary, bit 1 is the software interrupt, and bits 2 to N_SRC (24 by default) are hardware sources. Word addresses on `bus_addr`: 0 normal raw, 1 normal enable, 2 normal clear, 3 normal masked, 4 fast raw, 5 fast enable, 6 fast clear, 7 fast masked, 8 software-interrupt configuration. In the configuration word, bit 0 targets the normal level and bit 1 targets the fast level.

## Requirements
- R1: After reset both enable masks and the software-interrupt configuration are 0, `irq_o` and `fiq_o` are low, and `bus_rdata` is 0.
- R2: A raw register shows `src_req` bits 2..N_SRC where they are asserted. Bit 1 shows that level's software-interrupt configuration bit. Bit 0 and the bits above N_SRC read 0.
- R3: A write to an enable register sets every bit written as 1 and leaves every bit written as 0 unchanged. Reading the register returns the mask.
- R4: A write to a clear register clears every enable bit written as 1 and leaves the others unchanged. A clear register reads as 0.
- R5: A masked register bit n (n >= 1) equals raw bit n AND enable bit n. Bit 1 is never masked. Masked bit 0 is the OR of masked bits 31..1.
- R6: `irq_o` is high in the cycle after any bit of the normal masked register is high, and low in the cycle after all of them are low.
- R7: `fiq_o` follows the fast masked register in the same way, one cycle later.
- R8: Setting a bit in one level's enable register clears the same bit in the other level's enable register. The two masks never share a set bit.
- R9: Enable-register writes to bits 0, 1 and above N_SRC have no effect. Clear-register writes cannot stop an injected software interrupt.
- R10: `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 32 | Level requests, synchronous to clk |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal exception request |
| fiq_o | output | 1 | Fast exception request |

## Verification
A change on `src_req` reaches the masked views at once and reaches `irq_o` or `fiq_o` at the next edge. A register write takes effect at its own edge, so the outputs respond one edge after that. Read data appears one edge after the address. The driver tasks stamp each expected value with the cycle number in which it is due, counted in rising edges. The monitor compares only at falling edges whose cycle stamp matches, so every check samples mid-cycle, after the last register on the path has loaded.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int SEL_W   = 4;
    localparam int SUM_BIT = 0;
    localparam int SWI_BIT = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_N_RAW = 4'd0,
        SEL_N_EN  = 4'd1,
        SEL_N_CLR = 4'd2,
        SEL_N_STA = 4'd3,
        SEL_F_RAW = 4'd4,
        SEL_F_EN  = 4'd5,
        SEL_F_CLR = 4'd6,
        SEL_F_STA = 4'd7,
        SEL_SWI   = 4'd8
    } reg_sel_e;
endpackage

// File: rtl/ic_enable_pair.sv
module ic_enable_pair #(
    parameter int REG_W = 32,
    parameter logic [REG_W-1:0] SRC_MASK = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ic_pkg::SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0]       wr_data,
    output logic [REG_W-1:0]       n_en,
    output logic [REG_W-1:0]       f_en
);
    typedef struct packed {
        logic [REG_W-1:0] n_en;
        logic [REG_W-1:0] f_en;
    } en_t;

    en_t st_d, st_q;
    logic [REG_W-1:0] n_set, n_clr, f_set, f_clr;

    always_comb begin
        n_set = '0;
        n_clr = '0;
        f_set = '0;
        f_clr = '0;
        if (wr_en) begin
            case (ic_pkg::reg_sel_e'(wr_sel))
                ic_pkg::SEL_N_EN:  n_set = wr_data & SRC_MASK;
                ic_pkg::SEL_N_CLR: n_clr = wr_data;
                ic_pkg::SEL_F_EN:  f_set = wr_data & SRC_MASK;
                ic_pkg::SEL_F_CLR: f_clr = wr_data;
                default: ;
            endcase
        end
        st_d.n_en = (st_q.n_en | n_set) & ~n_clr & ~f_set;
        st_d.f_en = (st_q.f_en | f_set) & ~f_clr & ~n_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign n_en = st_q.n_en;
    assign f_en = st_q.f_en;

    // R8: the masks never overlap
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.n_en & st_q.f_en) == '0);
    // R9: positions outside the hardware sources stay disabled
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.n_en | st_q.f_en) & ~SRC_MASK) == '0);
    // R4: a clear write removes every bit it names
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == ic_pkg::SEL_N_CLR) |=> ((st_q.n_en & $past(wr_data)) == '0));
    // R8: a fast-level set removes the bit from the normal level
    a_r8_steal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == ic_pkg::SEL_F_EN) |=> ((st_q.n_en & $past(wr_data)) == '0));
endmodule

// File: rtl/ic_level_view.sv
module ic_level_view #(
    parameter int REG_W = 32,
    parameter logic [REG_W-1:0] SRC_MASK = '0
) (
    input  logic [REG_W-1:0] src_req,
    input  logic [REG_W-1:0] enable,
    input  logic             swi_hit,
    output logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] sta,
    output logic             req
);
    logic [REG_W-1:0] pass;

    always_comb begin
        raw = src_req & SRC_MASK;
        raw[ic_pkg::SWI_BIT] = swi_hit;
        pass = raw & (enable | (REG_W'(1) << ic_pkg::SWI_BIT));
        req = |pass[REG_W-1:1];
        sta = pass;
        sta[ic_pkg::SUM_BIT] = req;
    end
endmodule

// File: rtl/irq_dual_router.sv
module irq_dual_router #(
    parameter int REG_W = 32,
    parameter int N_SRC = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [REG_W-1:0]         src_req,
    input  logic [ic_pkg::SEL_W-1:0] bus_addr,
    input  logic                     bus_we,
    input  logic [REG_W-1:0]         bus_wdata,
    output logic [REG_W-1:0]         bus_rdata,
    output logic                     irq_o,
    output logic                     fiq_o
);
    localparam int N_LVL = 2;
    localparam logic [REG_W-1:0] SRC_MASK =
        ((REG_W'(1) << (N_SRC + 1)) - REG_W'(1)) & ~REG_W'(3);

    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic [N_LVL-1:0] swi;
        logic             irq;
        logic             fiq;
    } top_t;

    top_t st_d, st_q;
    logic [REG_W-1:0] en_v  [N_LVL];
    logic [REG_W-1:0] raw_v [N_LVL];
    logic [REG_W-1:0] sta_v [N_LVL];
    logic [N_LVL-1:0] req_v;

    ic_enable_pair #(.REG_W(REG_W), .SRC_MASK(SRC_MASK)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we),
        .wr_sel (bus_addr),
        .wr_data(bus_wdata),
        .n_en   (en_v[0]),
        .f_en   (en_v[1])
    );

    for (genvar lv = 0; lv < N_LVL; lv++) begin : g_lvl
        ic_level_view #(.REG_W(REG_W), .SRC_MASK(SRC_MASK)) u_view (
            .src_req(src_req),
            .enable (en_v[lv]),
            .swi_hit(st_q.swi[lv]),
            .raw    (raw_v[lv]),
            .sta    (sta_v[lv]),
            .req    (req_v[lv])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_we && bus_addr == ic_pkg::SEL_SWI)
            st_d.swi = bus_wdata[N_LVL-1:0];
        st_d.irq = req_v[0];
        st_d.fiq = req_v[1];
        case (ic_pkg::reg_sel_e'(bus_addr))
            ic_pkg::SEL_N_RAW: st_d.rdata = raw_v[0];
            ic_pkg::SEL_N_EN:  st_d.rdata = en_v[0];
            ic_pkg::SEL_N_STA: st_d.rdata = sta_v[0];
            ic_pkg::SEL_F_RAW: st_d.rdata = raw_v[1];
            ic_pkg::SEL_F_EN:  st_d.rdata = en_v[1];
            ic_pkg::SEL_F_STA: st_d.rdata = sta_v[1];
            ic_pkg::SEL_SWI:   st_d.rdata = REG_W'(st_q.swi);
            default:           st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = st_q.irq;
    assign fiq_o     = st_q.fiq;

    // R9: an injected normal interrupt cannot be masked
    a_r9_swi_n: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.swi[0] |=> irq_o);
    // R9: an injected fast interrupt cannot be masked
    a_r9_swi_f: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.swi[1] |=> fiq_o);
    // R6: a normal request needs an enabled line or an injection one cycle earlier
    a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past((src_req & en_v[0]) != '0) || $past(st_q.swi[0])));
    // R7: a fast request needs an enabled line or an injection one cycle earlier
    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> ($past((src_req & en_v[1]) != '0) || $past(st_q.swi[1])));
endmodule

// File: tb/sim_irq_dual_router.sv
`timescale 1ns/1ps
module sim_irq_dual_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    irq_dual_router u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          kind;
        int          due;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int kind, input int dly, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.due = cyc + dly; it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            it = sbq.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'b0, irq_o};
                default: act = {31'b0, fiq_o};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        expect_at(0, 1, e, tag);
    endtask

    task automatic outs(input logic i, input logic f, input string tag);
        expect_at(1, 1, {31'b0, i}, tag);
        expect_at(2, 1, {31'b0, f}, tag);
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_req = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        outs(0, 0, "R1 reset outputs");
        expect_at(0, 1, 32'h0, "R1 reset rdata");
        rd(4'd1, 32'h0, "R1 normal enable after reset");
        rd(4'd5, 32'h0, "R1 fast enable after reset");
        rd(4'd8, 32'h0, "R1 swi cfg after reset");

        set_src(32'h0000_0030);
        outs(0, 0, "R6 R7 lines but no enable");
        rd(4'd0, 32'h0000_0030, "R2 normal raw");
        rd(4'd3, 32'h0, "R5 normal masked empty");

        wr(4'd1, 32'h0000_0010);
        outs(1, 0, "R6 normal after enable");
        rd(4'd1, 32'h0000_0010, "R3 enable readback");
        rd(4'd3, 32'h0000_0011, "R5 masked with summary");
        wr(4'd1, 32'h0);
        rd(4'd1, 32'h0000_0010, "R3 zero write no change");

        wr(4'd5, 32'h0000_0030);
        outs(0, 1, "R7 fast after steal");
        rd(4'd5, 32'h0000_0030, "R3 fast enable readback");
        rd(4'd1, 32'h0, "R8 normal cleared by fast set");
        rd(4'd7, 32'h0000_0031, "R5 fast masked");

        wr(4'd1, 32'h0000_0020);
        outs(1, 1, "R8 both levels split");
        rd(4'd5, 32'h0000_0010, "R8 fast cleared by normal set");
        rd(4'd1, 32'h0000_0020, "R8 normal gained bit");

        wr(4'd6, 32'h0000_0010);
        outs(1, 0, "R4 fast cleared");
        rd(4'd5, 32'h0, "R4 fast enable after clear");
        rd(4'd6, 32'h0, "R4 clear reads zero");

        wr(4'd1, 32'hFE00_0003);
        rd(4'd1, 32'h0000_0020, "R9 reserved enable bits ignored");

        set_src(32'h0);
        outs(0, 0, "R6 line dropped");
        set_src(32'hFE00_0003);
        rd(4'd0, 32'h0, "R2 out-of-range lines hidden");
        outs(0, 0, "R6 out-of-range lines ignored");
        set_src(32'h0);

        wr(4'd8, 32'h1);
        outs(1, 0, "R9 swi on normal");
        rd(4'd0, 32'h0000_0002, "R2 swi in normal raw");
        rd(4'd3, 32'h0000_0003, "R5 swi in normal masked");
        rd(4'd4, 32'h0, "R2 fast raw no swi");
        wr(4'd2, 32'hFFFF_FFFF);
        outs(1, 0, "R9 swi survives clear");
        rd(4'd1, 32'h0, "R4 full clear");
        wr(4'd8, 32'h2);
        outs(0, 1, "R9 swi moved to fast");
        rd(4'd7, 32'h0000_0003, "R5 swi in fast masked");
        rd(4'd8, 32'h2, "R10 swi cfg readback");
        wr(4'd8, 32'h0);
        outs(0, 0, "R9 swi off");

        wr(4'd5, 32'h0100_0000);
        set_src(32'h0100_0000);
        outs(0, 1, "R7 top source");
        rd(4'd4, 32'h0100_0000, "R2 top source raw");
        rd(4'd7, 32'h0100_0001, "R10 fast masked read");

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule